// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is the slave end of a three-wire configuration link for a sensor signal-processing chip. A host drives a serial clock, a serial data line and an active-low load strobe. While the strobe is low, each rising serial-clock edge shifts in one frame bit. A frame starts with a direction bit, then three address bits, then up to ten data bits, and every field is sent least significant bit first. A write is applied when the strobe returns high. A read shifts the addressed register back out on a separate serial output.

The stored configuration is presented as parallel fields for downstream logic. These fields are the operating mode, output mode, clock and clamp-pulse polarity, power mode, black-clamp level (raw code and decoded LSB value), a 10-bit gain code, two 8-bit DAC codes, an offset-correction bypass and a DAC enable. The serial inputs are asynchronous to the system clock. They pass through a synchronizer, and every decision is made in the system clock domain.

Top module: `serial_cfg_port`

## Requirements
- R1: While `ser_ld_n` is low, `ser_din` is captured on each rising edge of `ser_clk`. Frame bit order: bit 0 is the direction bit (0 = write, 1 = read), bits 1..3 are the address LSB first, and bits 4..13 are data D0..D9. Address map: 1 = mode word, 2 = gain, 3 = DAC A, 4 = DAC B, 7 = misc. DAC writes keep D0..D7.
- R2: After reset, `op_mode` is 2'b11 and every other field is 0, including `dac_enable` and `ser_dout`.
- R3: A write changes its register only when `ser_ld_n` rises. All outputs stay unchanged while the frame is still being shifted.
- R4: Rising `ser_clk` edges after the fourteenth in a frame are ignored. A frame of 16 or 20 edges with trailing dummy bits writes and reads like a 14-edge frame.
- R5: Mode word layout: D1:D0 operating mode, D3:D2 output mode, D5:D4 clock polarity, D7:D6 power mode, D9:D8 clamp select. Misc word layout: D0 offset-correction bypass, D1 reserved (ignored on write, reads 0), D2 DAC enable.
- R6: A frame whose strobe rises before all four header bits arrive changes nothing. So does a write that carries fewer data bits than required: 10 normally, 8 for the exception in R7.
- R7: When `op_mode` is 2'b01 (auxiliary), a gain write needs only 8 data bits. It stores D0..D7 and clears the two upper gain bits.
- R8: For a read, data bit k appears on `ser_dout` after the falling `ser_clk` edge that follows rising edge 4+k. The master samples it on rising edge 5+k. Ten bits are returned, LSB first. Unused upper bits read 0. A read changes no register.
- R9: `ser_dout` is low whenever no read bit is being presented, including during write frames and while the strobe is high.
- R10: `clamp_lsb` decodes `clamp_sel` as 00→32, 01→48, 10→64, 11→16.
- R11: Writes to addresses 0, 5 and 6 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host (asynchronous) |
| ser_din | input | 1 | Serial data from host |
| ser_ld_n | input | 1 | Active-low frame/load strobe |
| ser_dout | output | 1 | Serial readback data |
| op_mode | output | 2 | Operating mode field |
| out_mode | output | 2 | Output mode field |
| clk_pol | output | 2 | Clock/clamp pulse polarity field |
| pwr_mode | output | 2 | Power mode field |
| clamp_sel | output | 2 | Clamp level select code |
| clamp_lsb | output | 7 | Decoded black-clamp level in LSB |
| gain_code | output | 10 | Gain register |
| dac_a_code | output | 8 | DAC A code |
| dac_b_code | output | 8 | DAC B code |
| ofs_bypass | output | 1 | Offset-correction bypass |
| dac_enable | output | 1 | Auxiliary DAC enable |

## Verification
Each serial pin passes through two synchronizer flops and one edge-history flop. A register therefore updates on the third system clock edge after `ser_ld_n` rises, and `ser_dout` moves on the third edge after a falling `ser_clk`. The bench holds each serial clock phase for eight system cycles. It samples `ser_dout` at the end of the low phase, just before the next rising edge, and checks parallel outputs 24 cycles after the strobe rises. Every sample therefore falls well after its result is due and before the next stimulus can disturb it. Register values are swept across gain codes, every value of every mode field, DAC codes and misc patterns. Expected values are computed arithmetically in the bench.

// File: rtl/scfg_pkg.sv
// Package: shared constants, mode encodings and the clamp-level decode
// for the three-wire configuration port.
// Assumes a 3-bit address field and 10-bit data words.
package scfg_pkg;

    localparam int ADDR_BITS = 3;
    localparam int WORD_BITS = 10;

    // Operating-mode encodings held in the low field of the mode word
    typedef enum logic [1:0] {
        OPM_DIRECT = 2'b00,
        OPM_AUX    = 2'b01,
        OPM_MID    = 2'b10,
        OPM_SENSOR = 2'b11
    } opm_e;

    // Register addresses (frame address bits, LSB first on the wire)
    localparam logic [2:0] ADR_MODE = 3'd1;
    localparam logic [2:0] ADR_GAIN = 3'd2;
    localparam logic [2:0] ADR_DACA = 3'd3;
    localparam logic [2:0] ADR_DACB = 3'd4;
    localparam logic [2:0] ADR_MISC = 3'd7;

    // Field positions inside the mode word
    localparam int FLD_OP    = 0;
    localparam int FLD_OUT   = 2;
    localparam int FLD_CLK   = 4;
    localparam int FLD_PWR   = 6;
    localparam int FLD_CLAMP = 8;

    // Bit positions inside the misc word
    localparam int MISC_OFS   = 0;
    localparam int MISC_DACEN = 2;

    // Clamp select code to black level in LSB
    function automatic logic [6:0] clamp_black(input logic [1:0] sel);
        logic [6:0] lvl;
        case (sel)
            2'b00:   lvl = 7'd32;
            2'b01:   lvl = 7'd48;
            2'b10:   lvl = 7'd64;
            default: lvl = 7'd16;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/scfg_sync.sv
// Module: multi-bit level synchronizer for the asynchronous serial pins.
// Each input bit gets its own flop chain of STAGES flops. IDLE gives the
// reset value per bit so that an idle-high strobe does not look like an
// edge just after reset. Assumes the inputs change slower than clk.
module scfg_sync #(
    parameter int               N_SIG  = 3,
    parameter int               STAGES = 2,
    parameter logic [N_SIG-1:0] IDLE   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] lvl
);

    genvar g;
    generate
        for (g = 0; g < N_SIG; g++) begin : g_sig
            logic [STAGES-1:0] chain;
            // Shift the pin level through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{IDLE[g]}};
                else        chain <= {chain[STAGES-2:0], din[g]};
            end
            assign lvl[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/scfg_frame_rx.sv
// Module: serial frame engine. It counts rising serial-clock edges,
// captures the frame bits, decides on strobe release whether a write is
// complete enough to commit, and shifts readback data out on falling
// edges. Assumes synchronized pin levels as inputs.
module scfg_frame_rx #(
    parameter int DATA_W   = 10,
    parameter int ADDR_W   = 3,
    parameter int AUX_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_lvl,
    input  logic              sdi_lvl,
    input  logic              ld_lvl,
    input  logic              aux_mode,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo
);
    import scfg_pkg::*;

    localparam int HDR   = 1 + ADDR_W;
    localparam int FRAME = HDR + DATA_W;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR);
    localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(FRAME);
    localparam logic [CNT_W-1:0] AUXN_C  = CNT_W'(HDR + AUX_BITS);

    logic             sck_d, ld_d;
    logic             sck_rise, sck_fall, ld_rise;
    logic [CNT_W-1:0] cnt;
    logic [FRAME-1:0] fbits;
    logic [DATA_W-1:0] rsh;
    logic             sdo_q;
    logic             rnw;
    logic [ADDR_W-1:0] addr_f;
    logic [CNT_W-1:0] need_c;

    // Keep the previous pin levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            ld_d  <= 1'b1;
        end else begin
            sck_d <= sck_lvl;
            ld_d  <= ld_lvl;
        end
    end

    assign sck_rise = sck_lvl & ~sck_d;
    assign sck_fall = ~sck_lvl & sck_d;
    assign ld_rise  = ld_lvl & ~ld_d;

    // Count rising edges in the frame, saturating at the frame length
    always_ff @(posedge clk) begin
        if (!rst_n || ld_lvl)                 cnt <= '0;
        else if (sck_rise && cnt < FRAME_C)   cnt <= cnt + 1'b1;
    end

    // Capture each frame bit into the slot given by the edge count
    always_ff @(posedge clk) begin
        if (!rst_n || ld_lvl) begin
            fbits <= '0;
        end else if (sck_rise) begin
            for (int i = 0; i < FRAME; i++) begin
                if (cnt == CNT_W'(i)) fbits[i] <= sdi_lvl;
            end
        end
    end

    assign rnw     = fbits[0];
    assign addr_f  = fbits[HDR-1:1];
    assign wr_addr = addr_f;
    assign rd_addr = addr_f;
    assign wr_data = fbits[FRAME-1:HDR];

    // Data bits a write must carry before it may commit
    always_comb begin
        if (aux_mode && addr_f == ADDR_W'(ADR_GAIN)) need_c = AUXN_C;
        else                                          need_c = FRAME_C;
    end

    assign wr_en = ld_rise & ~rnw & (cnt >= need_c);

    // Shift readback bits out on falling serial-clock edges
    always_ff @(posedge clk) begin
        if (!rst_n || ld_lvl) begin
            rsh   <= '0;
            sdo_q <= 1'b0;
        end else if (sck_fall) begin
            if (rnw && cnt == HDR_C) begin
                sdo_q <= rd_data[0];
                rsh   <= rd_data >> 1;
            end else if (rnw && cnt > HDR_C && cnt < FRAME_C) begin
                sdo_q <= rsh[0];
                rsh   <= rsh >> 1;
            end else begin
                sdo_q <= 1'b0;
            end
        end
    end

    assign sdo = sdo_q;

    AST_EDGE_CAP: assert property (@(posedge clk) disable iff (!rst_n) (cnt == FRAME_C && sck_rise && !ld_lvl) |=> (cnt == FRAME_C && $stable(fbits))); // R4
    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ld_lvl |=> !sdo_q); // R9
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (!rnw && !ld_lvl) |=> !sdo_q); // R9

endmodule

// File: rtl/scfg_regs.sv
// Module: configuration register file. It holds the mode word, gain,
// two DAC codes and the misc bits, applies committed writes and muxes
// the addressed word for readback. Assumes wr_en is a single-cycle pulse.
module scfg_regs #(
    parameter int DATA_W   = 10,
    parameter int ADDR_W   = 3,
    parameter int GAIN_W   = 10,
    parameter int DAC_W    = 8,
    parameter int AUX_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mode_q,
    output logic [GAIN_W-1:0] gain_q,
    output logic [DAC_W-1:0]  daca_q,
    output logic [DAC_W-1:0]  dacb_q,
    output logic              ofs_q,
    output logic              dacen_q,
    output logic              aux_mode
);
    import scfg_pkg::*;

    localparam logic [DATA_W-1:0] MODE_RST = DATA_W'(OPM_SENSOR);

    logic wr_mode, wr_gain, wr_daca, wr_dacb, wr_misc, mapped;

    assign aux_mode = (mode_q[FLD_OP +: 2] == OPM_AUX);

    assign wr_mode = wr_en && wr_addr == ADDR_W'(ADR_MODE);
    assign wr_gain = wr_en && wr_addr == ADDR_W'(ADR_GAIN);
    assign wr_daca = wr_en && wr_addr == ADDR_W'(ADR_DACA);
    assign wr_dacb = wr_en && wr_addr == ADDR_W'(ADR_DACB);
    assign wr_misc = wr_en && wr_addr == ADDR_W'(ADR_MISC);
    assign mapped  = wr_mode | wr_gain | wr_daca | wr_dacb | wr_misc;

    // Mode word: resets to the image-sensor operating mode
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RST;
        else if (wr_mode) mode_q <= wr_data;
    end

    // Gain: auxiliary mode keeps only the low byte
    always_ff @(posedge clk) begin
        if (!rst_n)        gain_q <= '0;
        else if (wr_gain)  gain_q <= aux_mode ? GAIN_W'(wr_data[AUX_BITS-1:0])
                                              : wr_data[GAIN_W-1:0];
    end

    // DAC codes: low byte of the data word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            daca_q <= '0;
            dacb_q <= '0;
        end else begin
            if (wr_daca) daca_q <= wr_data[DAC_W-1:0];
            if (wr_dacb) dacb_q <= wr_data[DAC_W-1:0];
        end
    end

    // Misc bits: reserved bit is not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q   <= 1'b0;
            dacen_q <= 1'b0;
        end else if (wr_misc) begin
            ofs_q   <= wr_data[MISC_OFS];
            dacen_q <= wr_data[MISC_DACEN];
        end
    end

    // Readback mux; unmapped addresses return zero
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_MODE))      rd_data = mode_q;
        else if (rd_addr == ADDR_W'(ADR_GAIN)) rd_data = DATA_W'(gain_q);
        else if (rd_addr == ADDR_W'(ADR_DACA)) rd_data = DATA_W'(daca_q);
        else if (rd_addr == ADDR_W'(ADR_DACB)) rd_data = DATA_W'(dacb_q);
        else if (rd_addr == ADDR_W'(ADR_MISC)) begin
            rd_data[MISC_OFS]   = ofs_q;
            rd_data[MISC_DACEN] = dacen_q;
        end
    end

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable({mode_q, gain_q, daca_q, dacb_q, ofs_q, dacen_q})); // R3
    AST_AUX_GAIN: assert property (@(posedge clk) disable iff (!rst_n) (wr_gain && aux_mode) |=> (gain_q[GAIN_W-1:AUX_BITS] == '0)); // R7
    AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !mapped) |=> $stable({mode_q, gain_q, daca_q, dacb_q, ofs_q, dacen_q})); // R11

endmodule

// File: rtl/serial_cfg_port.sv
// Module: top of the three-wire configuration port. It synchronizes the
// serial pins, runs the frame engine and the register file, and fans the
// stored words out as named parallel fields. Assumes ser_ld_n idles high.
module serial_cfg_port #(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 10,
    parameter int ADDR_W      = 3,
    parameter int GAIN_W      = 10,
    parameter int DAC_W       = 8,
    parameter int AUX_BITS    = 8,
    parameter int CLAMP_W     = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_din,
    input  logic               ser_ld_n,
    output logic               ser_dout,
    output logic [1:0]         op_mode,
    output logic [1:0]         out_mode,
    output logic [1:0]         clk_pol,
    output logic [1:0]         pwr_mode,
    output logic [1:0]         clamp_sel,
    output logic [CLAMP_W-1:0] clamp_lsb,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [DAC_W-1:0]   dac_a_code,
    output logic [DAC_W-1:0]   dac_b_code,
    output logic               ofs_bypass,
    output logic               dac_enable
);
    import scfg_pkg::*;

    localparam int PIN_N = 3;

    logic [PIN_N-1:0]  pin_lvl;
    logic              wr_en, aux_mode;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data, mode_q;

    scfg_sync #(
        .N_SIG  (PIN_N),
        .STAGES (SYNC_STAGES),
        .IDLE   (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_ld_n, ser_din, ser_clk}),
        .lvl   (pin_lvl)
    );

    scfg_frame_rx #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .AUX_BITS (AUX_BITS)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_lvl  (pin_lvl[0]),
        .sdi_lvl  (pin_lvl[1]),
        .ld_lvl   (pin_lvl[2]),
        .aux_mode (aux_mode),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .sdo      (ser_dout)
    );

    scfg_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .GAIN_W   (GAIN_W),
        .DAC_W    (DAC_W),
        .AUX_BITS (AUX_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .mode_q   (mode_q),
        .gain_q   (gain_code),
        .daca_q   (dac_a_code),
        .dacb_q   (dac_b_code),
        .ofs_q    (ofs_bypass),
        .dacen_q  (dac_enable),
        .aux_mode (aux_mode)
    );

    assign op_mode   = mode_q[FLD_OP    +: 2];
    assign out_mode  = mode_q[FLD_OUT   +: 2];
    assign clk_pol   = mode_q[FLD_CLK   +: 2];
    assign pwr_mode  = mode_q[FLD_PWR   +: 2];
    assign clamp_sel = mode_q[FLD_CLAMP +: 2];
    assign clamp_lsb = CLAMP_W'(clamp_black(clamp_sel));

endmodule

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
// Bench: drives three-wire frames with a slow serial clock and checks the
// parallel fields and readback against values computed from the rules.
module sim_serial_cfg_port;

    localparam int H = 8;   // system cycles per serial clock phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, ld_n = 1'b1;
    logic sdo;
    logic [1:0] op_mode, out_mode, clk_pol, pwr_mode, clamp_sel;
    logic [6:0] clamp_lsb;
    logic [9:0] gain_code;
    logic [7:0] dac_a_code, dac_b_code;
    logic ofs_bypass, dac_enable;
    logic [37:0] st, st_pre, st_mid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    serial_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_din(sdi), .ser_ld_n(ld_n),
        .ser_dout(sdo), .op_mode(op_mode), .out_mode(out_mode), .clk_pol(clk_pol),
        .pwr_mode(pwr_mode), .clamp_sel(clamp_sel), .clamp_lsb(clamp_lsb),
        .gain_code(gain_code), .dac_a_code(dac_a_code), .dac_b_code(dac_b_code),
        .ofs_bypass(ofs_bypass), .dac_enable(dac_enable)
    );

    assign st = {op_mode, out_mode, clk_pol, pwr_mode, clamp_sel, gain_code,
                 dac_a_code, dac_b_code, ofs_bypass, dac_enable};

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, got %0d cycles exp fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d exp %0d", req, what, got, exp);
        end
    endtask

    // One frame of nbits rising edges; bits past 14 are dummy ones.
    task automatic xfer(input bit rnw, input int adr, input int data, input int nbits, output int rd);
        rd = 0;
        st_pre = st;
        ld_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i == 0)       sdi = rnw;
            else if (i < 4)   sdi = 1'((adr >> (i - 1)) & 1);
            else if (i < 14)  sdi = 1'((data >> (i - 4)) & 1);
            else              sdi = 1'b1;
            repeat (H) @(negedge clk);
            if (i >= 4 && i < 14) rd = rd | (int'(sdo) << (i - 4));
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        st_mid = st;
        ld_n = 1'b1;
        repeat (3 * H) @(negedge clk);
    endtask

    task automatic wr(input int adr, input int data, input int nbits);
        int rd;
        xfer(1'b0, adr, data, nbits, rd);
        chk("R9", "sdo during write frame", rd, 0);
    endtask

    task automatic rdreg(input int adr, output int val);
        xfer(1'b1, adr, 0, 14, val);
    endtask

    function automatic int clamp_exp(input int c);
        return (c == 3) ? 16 : 32 + 16 * c;
    endfunction

    initial begin
        int rv, exp_mode;
        logic [37:0] keep;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 reset state
        chk("R2", "op_mode", op_mode, 3);
        chk("R2", "out/clk/pwr/clamp", {out_mode, clk_pol, pwr_mode, clamp_sel}, 0);
        chk("R2", "gain", gain_code, 0);
        chk("R2", "dacs", {dac_a_code, dac_b_code}, 0);
        chk("R2", "misc", {ofs_bypass, dac_enable}, 0);
        chk("R2", "sdo", sdo, 0);
        chk("R10", "clamp_lsb reset", clamp_lsb, 32);
        rdreg(1, rv);
        chk("R8", "read mode reset", rv, 3);

        // R1 R3 R8 gain sweep with readback
        for (int v = 0; v < 1024; v += 31) begin
            wr(2, v, 14);
            chk("R3", "outputs held mid-frame", st_mid, st_pre);
            chk("R1", "gain write", gain_code, v);
            rdreg(2, rv);
            chk("R8", "gain readback", rv, v);
        end
        wr(2, 1023, 14);
        chk("R1", "gain all ones", gain_code, 1023);

        // R5 R10 every value of every mode field
        for (int f = 0; f < 5; f++) begin
            for (int c = 0; c < 4; c++) begin
                exp_mode = (f == 0) ? c : (3 | (c << (2 * f)));
                wr(1, exp_mode, 14);
                chk("R5", "op field", op_mode, exp_mode & 3);
                chk("R5", "out field", out_mode, (exp_mode >> 2) & 3);
                chk("R5", "clk field", clk_pol, (exp_mode >> 4) & 3);
                chk("R5", "pwr field", pwr_mode, (exp_mode >> 6) & 3);
                chk("R5", "clamp field", clamp_sel, (exp_mode >> 8) & 3);
                chk("R10", "clamp level", clamp_lsb, clamp_exp((exp_mode >> 8) & 3));
                rdreg(1, rv);
                chk("R8", "mode readback", rv, exp_mode);
            end
        end
        wr(1, 3, 14);

        // R1 R8 DAC codes; upper data bits are not stored
        for (int v = 0; v < 256; v += 15) begin
            wr(3, v | 768, 14);
            wr(4, (255 - v) | 512, 14);
            chk("R1", "dac A", dac_a_code, v);
            chk("R1", "dac B", dac_b_code, 255 - v);
            rdreg(3, rv);
            chk("R8", "dac A readback", rv, v);
            rdreg(4, rv);
            chk("R8", "dac B readback", rv, 255 - v);
        end

        // R5 misc word
        wr(7, 5, 14);
        chk("R5", "misc ofs/en", {ofs_bypass, dac_enable}, 3);
        rdreg(7, rv);
        chk("R5", "misc readback", rv, 5);
        wr(7, 7, 14);
        rdreg(7, rv);
        chk("R5", "reserved bit ignored", rv, 5);
        wr(7, 2, 14);
        chk("R5", "misc cleared", {ofs_bypass, dac_enable}, 0);
        wr(7, 4, 14);
        chk("R5", "dac enable only", {ofs_bypass, dac_enable}, 1);

        // R11 unmapped addresses
        foreach (keep[i]) keep[i] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            int a;
            a = (k == 0) ? 0 : 4 + k;
            keep = st;
            wr(a, 1023, 14);
            chk("R11", "unmapped write", st, keep);
            rdreg(a, rv);
            chk("R11", "unmapped read", rv, 0);
        end

        // R4 extra clock edges ignored
        wr(2, 677, 16);
        chk("R4", "16-edge write", gain_code, 677);
        wr(2, 346, 20);
        chk("R4", "20-edge write", gain_code, 346);
        xfer(1'b1, 2, 0, 16, rv);
        chk("R4", "16-edge read", rv, 346);
        chk("R9", "sdo idle after read", sdo, 0);

        // R6 truncated frames
        keep = st;
        wr(2, 1023, 3);
        chk("R6", "header cut short", st, keep);
        wr(2, 1023, 13);
        chk("R6", "nine data bits in sensor mode", st, keep);
        wr(1, 0, 0);
        chk("R6", "bare strobe pulse", st, keep);
        wr(2, 255, 12);
        chk("R6", "eight data bits outside aux", gain_code, 346);

        // R7 auxiliary-mode gain
        wr(1, 1, 14);
        chk("R7", "aux mode entered", op_mode, 1);
        wr(2, 195, 12);
        chk("R7", "8-bit gain write", gain_code, 195);
        wr(2, 1023, 14);
        chk("R7", "upper gain bits cleared", gain_code, 255);
        wr(2, 127, 11);
        chk("R6", "seven data bits in aux", gain_code, 255);
        rdreg(2, rv);
        chk("R7", "aux gain readback", rv, 255);
        wr(1, 3, 14);

        // R8 read has no side effects
        keep = st;
        rdreg(1, rv);
        rdreg(2, rv);
        chk("R8", "reads leave state", st, keep);
        chk("R9", "sdo idle", sdo, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule